// File: doc/BRIEF.md
# Signed-Term Adder Tree Reducer

This block collapses a fixed group of signed input terms into a single sum. Every term is scaled by its own power of two and marked as either added or subtracted. The terms feed the leaf slots of a complete binary tree of two-input add/sub nodes. A parameter map places each term in one leaf slot and may leave slots empty. An empty slot lets a term pass one or more levels unchanged, so a term that arrives late can sit higher in the tree.

Each node reads the static sign tags of its two operands. Equal tags give an addition. Unequal tags give the left operand minus the right operand. The tag of the left operand is carried upward. Because of this, the root result can carry a negative tag. The block does not negate the result internally. It reports the tag as a flag, so a following accumulator stage can subtract the result instead of adding it.

Data enters and leaves through valid/ready handshakes. A mask parameter chooses after which tree levels a register stage sits. The whole pipeline advances together whenever the output is empty or is being taken. Back-pressure therefore stalls every stage at once. A result that is offered stays unchanged until it is accepted.

Top module: `adt_reducer`

## Requirements
- R1: A node whose two present operands carry equal sign tags outputs their sum and keeps that tag.
- R2: A node whose two present operands carry unequal tags outputs left minus right and takes the left operand's tag.
- R3: A node with only one present operand passes that operand's value and tag unchanged. `out_neg` therefore equals the tag of the leftmost occupied leaf slot: 1 (subtract) for the default map.
- R4: When `out_valid` is high, `out_sum` negated if `out_neg` is 1 equals the sum over all terms of ±(term × 2^shift), using − for terms marked in `TERM_NEG`. The tree itself never applies the final negation.
- R5: Term i is taken from `in_terms[i*IN_W +: IN_W]` as two's complement and shifted left by `TERM_SHIFT[i]` before it enters the tree. Default shifts for terms 0..4 are 0,1,2,3,0. Default negative terms are 1, 2 and 4.
- R6: Value width grows by one bit per level, from IN_W+MAX_SHIFT at the leaves to IN_W+MAX_SHIFT+LEVELS at the root. Operands are sign-extended before each node operation, so extreme inputs never overflow.
- R7: Latency from an accepting edge to `out_valid` equals the number of set bits in `REG_MASK`: 2 edges with the default 3'b101.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_sum` and `out_neg` hold steady.
- R9: `in_ready` is high exactly when `out_ready` is high or `out_valid` is low. After the only result is taken, `out_valid` drops on the next edge.
- R10: While reset is held, and right after it, `out_valid` is low.
- R11: Empty leaf slots contribute nothing to the sum. A term with no partner at some level reaches the root with its value intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for the valid flags |
| in_valid | input | 1 | Input terms are offered |
| in_ready | output | 1 | Input is taken on this edge if valid |
| in_terms | input | N_TERMS*IN_W | Packed signed terms, term i at bits i*IN_W upward |
| out_valid | output | 1 | Result is offered |
| out_ready | input | 1 | Downstream takes the result |
| out_sum | output | IN_W+MAX_SHIFT+LEVELS | Uncorrected tree result, two's complement |
| out_neg | output | 1 | 1: downstream must subtract `out_sum` |

## Verification
The handshake assertions take for granted that the upstream side never offers data while reset is held. They also assume that `out_ready` is a clean level and never unknown. The bench meets both conditions: it offers one vector at a time and keeps `out_ready` low until it has seen a result and checked that the result holds steady. The vectors include single-term cases, all-maximum and all-minimum cases, and a large random set. Each result is compared to a sum that the bench computes itself from the shift and sign parameters.

// File: rtl/adt_pkg.sv
package adt_pkg;
  function automatic int count_set(input logic [31:0] m);
    int c;
    c = 0;
    for (int i = 0; i < 32; i++) c += int'(m[i]);
    return c;
  endfunction
endpackage

// File: rtl/adt_leaf.sv
module adt_leaf #(
  parameter int IN_W    = 8,
  parameter int OUT_W   = 11,
  parameter int SHIFT   = 0,
  parameter bit PRESENT = 1'b1
) (
  input  logic signed [IN_W-1:0]  term,
  output logic signed [OUT_W-1:0] y
);
  logic signed [OUT_W-1:0] ext;
  assign ext = {{(OUT_W-IN_W){term[IN_W-1]}}, term};
  assign y   = PRESENT ? (ext <<< SHIFT) : '0;
endmodule

// File: rtl/adt_node.sv
module adt_node #(
  parameter int IN_W   = 11,
  parameter bit L_PRES = 1'b1,
  parameter bit R_PRES = 1'b1,
  parameter bit SUB    = 1'b0
) (
  input  logic signed [IN_W-1:0] a,
  input  logic signed [IN_W-1:0] b,
  output logic signed [IN_W:0]   y
);
  logic signed [IN_W:0] ax, bx;
  assign ax = {a[IN_W-1], a};
  assign bx = {b[IN_W-1], b};

  always_comb begin
    if (!L_PRES)      y = bx;
    else if (!R_PRES) y = ax;
    else if (SUB)     y = ax - bx;
    else              y = ax + bx;
  end
endmodule

// File: rtl/adt_stage.sv
module adt_stage #(
  parameter int W   = 12,
  parameter bit REG = 1'b1
) (
  input  logic         clk,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  if (REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (en) q <= d;
    end
  end else begin : g_wire
    logic unused_ok;
    assign unused_ok = &{1'b0, clk, en};
    assign q = d;
  end
endmodule

// File: rtl/adt_reducer.sv
module adt_reducer #(
  parameter int IN_W       = 8,
  parameter int N_TERMS    = 5,
  parameter int LEVELS     = 3,
  parameter int MAX_SHIFT  = 3,
  parameter int LEAF_MAP   [2**LEVELS] = '{1, 0, 2, -1, 3, 4, -1, -1},
  parameter int TERM_SHIFT [N_TERMS]   = '{0, 1, 2, 3, 0},
  parameter logic [N_TERMS-1:0] TERM_NEG = 5'b10110,
  parameter logic [LEVELS-1:0]  REG_MASK = 3'b101
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   in_valid,
  output logic                                   in_ready,
  input  logic [N_TERMS*IN_W-1:0]                in_terms,
  output logic                                   out_valid,
  input  logic                                   out_ready,
  output logic signed [IN_W+MAX_SHIFT+LEVELS-1:0] out_sum,
  output logic                                   out_neg
);
  import adt_pkg::*;

  localparam int SLOTS  = 2**LEVELS;
  localparam int BASE_W = IN_W + MAX_SHIFT;
  localparam int OUT_W  = BASE_W + LEVELS;
  localparam int LAT    = count_set(32'(REG_MASK));

  function automatic bit slot_present(input int lvl, input int idx);
    for (int s = idx << lvl; s < ((idx + 1) << lvl); s++)
      if (LEAF_MAP[s] >= 0) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit slot_neg(input int lvl, input int idx);
    for (int s = idx << lvl; s < ((idx + 1) << lvl); s++)
      if (LEAF_MAP[s] >= 0) return TERM_NEG[LEAF_MAP[s]];
    return 1'b0;
  endfunction

  logic adv;
  assign adv      = out_ready || !out_valid;
  assign in_ready = adv;

  for (genvar k = 0; k <= LEVELS; k++) begin : lvl
    localparam int W  = BASE_W + k;
    localparam int NN = SLOTS >> k;
    logic signed [W-1:0] v [NN];
    logic                vo;

    if (k == 0) begin : g_leaf
      assign vo = in_valid;
      for (genvar i = 0; i < NN; i++) begin : g_slot
        localparam bit PRES = (LEAF_MAP[i] >= 0);
        localparam int TI   = PRES ? LEAF_MAP[i] : 0;
        localparam int SH   = PRES ? TERM_SHIFT[TI] : 0;
        logic signed [IN_W-1:0] t;
        assign t = PRES ? in_terms[TI*IN_W +: IN_W] : '0;
        adt_leaf #(.IN_W(IN_W), .OUT_W(W), .SHIFT(SH), .PRESENT(PRES)) u_leaf (
          .term(t), .y(v[i])
        );
      end
    end else begin : g_node
      if (REG_MASK[k-1]) begin : g_vreg
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)   vo <= 1'b0;
          else if (adv) vo <= lvl[k-1].vo;
        end
      end else begin : g_vwire
        assign vo = lvl[k-1].vo;
      end
      for (genvar i = 0; i < NN; i++) begin : g_op
        localparam bit LP  = slot_present(k-1, 2*i);
        localparam bit RP  = slot_present(k-1, 2*i+1);
        localparam bit SUB = LP && RP && (slot_neg(k-1, 2*i) != slot_neg(k-1, 2*i+1));
        logic signed [W-1:0] sum;
        adt_node #(.IN_W(W-1), .L_PRES(LP), .R_PRES(RP), .SUB(SUB)) u_node (
          .a(lvl[k-1].v[2*i]), .b(lvl[k-1].v[2*i+1]), .y(sum)
        );
        adt_stage #(.W(W), .REG(REG_MASK[k-1])) u_stage (
          .clk(clk), .en(adv), .d(sum), .q(v[i])
        );
      end
    end
  end

  assign out_valid = lvl[LEVELS].vo;
  assign out_sum   = lvl[LEVELS].v[0];
  assign out_neg   = slot_neg(LEVELS, 0);
endmodule

// File: rtl/adt_reducer_chk.sv
module adt_reducer_chk #(
  parameter int LAT   = 2,
  parameter int OUT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_sum,
  input logic             out_neg
);
  int occ;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= 0;
    else occ <= occ + int'(in_valid && in_ready) - int'(out_valid && out_ready);
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum) && $stable(out_neg)));

  p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid || out_ready) |-> in_ready);

  p_occ_r7: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= LAT);

  p_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (LAT > 0 && out_valid) |-> (occ > 0));

  p_known_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown(out_sum));
endmodule

bind adt_reducer adt_reducer_chk #(.LAT(LAT), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_sum(out_sum), .out_neg(out_neg)
);

// File: tb/adt_reducer_tb.sv
module adt_reducer_tb;
  localparam int IN_W = 8, NT = 5, LEVELS = 3, MAXS = 3;
  localparam int OUT_W = IN_W + MAXS + LEVELS;
  localparam int SH [NT] = '{0, 1, 2, 3, 0};
  localparam logic [NT-1:0] NEG = 5'b10110;
  localparam int EXP_LAT = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [NT*IN_W-1:0] in_terms = '0;
  logic in_ready, out_valid, out_neg;
  logic signed [OUT_W-1:0] out_sum;
  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  adt_reducer u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_terms(in_terms), .out_valid(out_valid), .out_ready(out_ready),
    .out_sum(out_sum), .out_neg(out_neg)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input int t [NT], input string tag);
    int ref_sum, got, lat, guard;
    ref_sum = 0;
    for (int i = 0; i < NT; i++) begin
      in_terms[i*IN_W +: IN_W] = IN_W'(t[i]);
      ref_sum += (NEG[i] ? -1 : 1) * (t[i] * (1 << SH[i]));
    end
    in_valid = 1'b1;
    check(in_ready == 1'b1, "R9 idle ready", int'(in_ready), 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1; guard = 0;
    while (!out_valid && guard < 20) begin
      @(negedge clk); lat++; guard++;
    end
    check(lat == EXP_LAT, {"R7 latency ", tag}, lat, EXP_LAT);
    got = int'(out_sum);
    // R3: leftmost occupied slot holds term 1, tagged negative
    check(out_neg == 1'b1, {"R3 root sign ", tag}, int'(out_neg), 1);
    check((out_neg ? -got : got) == ref_sum, {"R4 sum ", tag}, out_neg ? -got : got, ref_sum);
    check(got == -ref_sum, {"R4 uncorrected ", tag}, got, -ref_sum);
    @(negedge clk);
    @(negedge clk);
    check(out_valid && int'(out_sum) == got, {"R8 hold ", tag}, int'(out_sum), got);
    check(in_ready == 1'b0, {"R9 stalled ready ", tag}, int'(in_ready), 0);
    out_ready = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, {"R9 drained ", tag}, int'(out_valid), 0);
    out_ready = 1'b0;
  endtask

  initial begin
    #3000000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    int t [NT];
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R10 in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R10 after reset", int'(out_valid), 0);

    // R5 / R11: one term at a time, each at both extremes
    for (int i = 0; i < NT; i++) begin
      for (int p = 0; p < 2; p++) begin
        t = '{0, 0, 0, 0, 0};
        t[i] = p ? 127 : -128;
        run_vec(t, "R5 R11 single");
      end
    end
    // R1 / R2: mixed-sign pairs at level 1, like-sign merge at level 2
    t = '{5, 3, 0, 0, 0};   run_vec(t, "R2 pair01");
    t = '{0, 0, 0, 7, 9};   run_vec(t, "R2 pair34");
    t = '{0, 4, 6, 0, 0};   run_vec(t, "R1 merge12");
    t = '{-9, 11, -13, 2, -1}; run_vec(t, "R1 R2 mix");
    // R6: extremes
    t = '{127, 127, 127, 127, 127};      run_vec(t, "R6 allmax");
    t = '{-128, -128, -128, -128, -128}; run_vec(t, "R6 allmin");
    t = '{127, -128, -128, 127, -128};   run_vec(t, "R6 worst");
    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < NT; i++) t[i] = $urandom_range(255) - 128;
      run_vec(t, "R4 random");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule